// File: doc/BRIEF.md
# SDRAM Command Sequencer with Periodic Refresh

This block sits between a simple host request port and a four-bank synchronous DRAM. After reset it waits out the power-up delay, closes every bank, performs two auto refreshes and programs the mode register. It then turns each accepted host request into a row activate followed by a single read or write. That column command carries the auto-precharge flag, so the row closes on its own. The data path is left to a companion pipeline that decodes the same command bus. All command timing is counted in clocks by a single gap counter. A free-running interval timer raises a refresh request, and that request is served at the next idle point ahead of any host request.

Every command leaves the block through a register. The four active-low strobes are driven as chip select, row strobe, column strobe and write enable. A host address is split into bank (top two bits), row (next twelve) and column (low nine).

Top module: `sdram_cmd_seq`

## Requirements
- R1: The strobes {cs_n, ras_n, cas_n, we_n} carry only these codes: 0000 mode set, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 auto refresh, 0111 no-op. In reset and whenever no command is due, the output is no-op.
- R2: From reset until the mode register is set, `req_ready` and `init_done` stay low and no activate, read or write appears. The first command is issued T_INIT clocks after reset is released.
- R3: The start-up order is fixed, and each step follows the one before it at a fixed distance. The steps are: precharge with address bit 10 high, then T_RP later an auto refresh, then T_RC later a second auto refresh, then T_RC later a mode set. The mode set has bank bits 00 and an address word whose bits 6:4 hold CAS_LAT and whose other bits are zero (single-beat, sequential, burst write).
- R4: After the mode set, the next command comes no sooner than T_MRD clocks later. `init_done` is high from the clock that follows the mode set.
- R5: A request accepted at a clock edge (valid and ready both high) produces an activate at that same edge. The activate carries bank = addr[22:21] and row = addr[20:9].
- R6: Exactly T_RCD clocks after the activate, a read or write is issued (write when `req_write` was high). It goes to the same bank, with address bits 8:0 equal to addr[8:0], bit 10 high and the other bits zero. Only no-ops lie between the two commands.
- R7: After a read, the next activate or refresh comes max(T_RC, T_RAS_MIN+T_RP, T_RCD+1) − T_RCD clocks later. After a write the distance is max(T_RC, T_RAS_MIN+T_RP, T_RCD+T_WR+T_RP) − T_RCD. After a refresh it is T_RC. Activates are at least max(T_RC, T_RRD) apart. A waiting request is served exactly when these limits allow.
- R8: After start-up, a refresh falls due every T_REFI clocks. On an idle port, consecutive refreshes are exactly T_REFI apart. Under traffic, each refresh is issued at most T_RCD plus the write recovery distance after it fell due.
- R9: A due refresh is served before a waiting host request. Continuous back-to-back traffic never delays a refresh beyond the R8 bound.
- R10: `req_ready` is high only in the idle state with no gap outstanding and no refresh due. It is low from a refresh until T_RC clocks have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at the next edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | {bank[1:0], row[11:0], column[8:0]} |
| init_done | output | 1 | Start-up sequence finished |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Row / column / mode word; bit 10 is the auto-precharge and all-banks flag |

## Verification
The hardest situation to reach is a refresh falling due while the host keeps the port saturated, so that the refresh and a waiting request compete at the same idle point. The stimulus holds `req_valid` high through a long back-to-back sweep over every bank, direction and a spread of rows and columns. That stream spans several refresh periods, so ticks land at every phase of an access. The bench tracks the earliest legal cycle for each command and flags any idle no-op while a request waits. It also checks each refresh's distance from its due point, and on a quiet port it requires that distance to be zero.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_REF1,
    ST_REF2,
    ST_MRS,
    ST_IDLE,
    ST_COL
  } seq_st_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_seq_gap.sv
// Down-counter holding off the next command; busy while nonzero.
module sdram_seq_gap #(
  parameter int unsigned CW       = 8,
  parameter int unsigned INIT_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= CW'(INIT_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/sdram_seq_refi.sv
// Free-running refresh interval timer with a sticky pending flag.
module sdram_seq_refi #(
  parameter int unsigned PERIOD = 1562
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ack,
  output logic pend
);
  localparam int unsigned W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt;
  logic         tick;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (en) cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_seq_cmdreg.sv
// Output register for the command strobes and address lines.
module sdram_seq_cmdreg
  import sdram_seq_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              cmd,
  input  logic [BANK_W-1:0] ba,
  input  logic [ROW_W-1:0]  addr,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba_q,
  output logic [ROW_W-1:0]  addr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= cmd;
      ba_q   <= ba;
      addr_q <= addr;
    end
  end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned COL_W     = 9,
  parameter int unsigned T_INIT    = 20000,
  parameter int unsigned T_REFI    = 1562,
  parameter int unsigned T_RCD     = 2,
  parameter int unsigned T_RP      = 2,
  parameter int unsigned T_RC      = 7,
  parameter int unsigned T_RAS_MIN = 5,
  parameter int unsigned T_RRD     = 2,
  parameter int unsigned T_WR      = 2,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned CAS_LAT   = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  output logic                            init_done,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]                sd_addr
);
  localparam int unsigned ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int unsigned AP_BIT = 10;
  localparam int unsigned ACT_SPAN = umax(T_RC, T_RRD);
  localparam int unsigned POST_RD =
    umax(umax(ACT_SPAN, T_RAS_MIN + T_RP), T_RCD + 1) - T_RCD;
  localparam int unsigned POST_WR =
    umax(umax(ACT_SPAN, T_RAS_MIN + T_RP), T_RCD + T_WR + T_RP) - T_RCD;
  localparam int unsigned GW =
    $clog2(T_INIT + T_RC + T_RCD + T_WR + T_RP + T_RAS_MIN + T_MRD + T_RRD + 2);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  seq_st_e             state, nx_state;
  cmd_e                nx_cmd;
  logic [BANK_W-1:0]   nx_ba, ba_q;
  logic [ROW_W-1:0]    nx_addr;
  logic [COL_W-1:0]    col_q;
  logic                wr_q;
  logic                gap_ld;
  logic [GW-1:0]       gap_val;
  logic                busy;
  logic                ref_pend, ref_ack;
  logic                take;
  logic                done_q;

  sdram_seq_gap #(.CW(GW), .INIT_VAL(T_INIT - 1)) u_gap (
    .clk(clk), .rst(rst), .load(gap_ld), .load_val(gap_val), .busy(busy)
  );

  sdram_seq_refi #(.PERIOD(T_REFI)) u_refi (
    .clk(clk), .rst(rst), .en(done_q), .ack(ref_ack), .pend(ref_pend)
  );

  sdram_seq_cmdreg #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_out (
    .clk(clk), .rst(rst), .cmd(nx_cmd), .ba(nx_ba), .addr(nx_addr),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .ba_q(sd_ba), .addr_q(sd_addr)
  );

  assign req_ready = (state == ST_IDLE) && !busy && !ref_pend;
  assign init_done = done_q;

  always_comb begin
    nx_state = state;
    nx_cmd   = CMD_NOP;
    nx_ba    = '0;
    nx_addr  = '0;
    gap_ld   = 1'b0;
    gap_val  = '0;
    ref_ack  = 1'b0;
    take     = 1'b0;
    if (!busy) begin
      unique case (state)
        ST_PWR: begin
          nx_cmd          = CMD_PRE;
          nx_addr[AP_BIT] = 1'b1;
          gap_ld          = 1'b1;
          gap_val         = GW'(T_RP - 1);
          nx_state        = ST_REF1;
        end
        ST_REF1: begin
          nx_cmd   = CMD_REF;
          gap_ld   = 1'b1;
          gap_val  = GW'(T_RC - 1);
          nx_state = ST_REF2;
        end
        ST_REF2: begin
          nx_cmd   = CMD_REF;
          gap_ld   = 1'b1;
          gap_val  = GW'(T_RC - 1);
          nx_state = ST_MRS;
        end
        ST_MRS: begin
          nx_cmd   = CMD_MRS;
          nx_addr  = MODE_WORD;
          gap_ld   = 1'b1;
          gap_val  = GW'(T_MRD - 1);
          nx_state = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            nx_cmd  = CMD_REF;
            ref_ack = 1'b1;
            gap_ld  = 1'b1;
            gap_val = GW'(T_RC - 1);
          end else if (req_valid) begin
            take     = 1'b1;
            nx_cmd   = CMD_ACT;
            nx_ba    = req_addr[ADDR_W-1 -: BANK_W];
            nx_addr  = req_addr[COL_W +: ROW_W];
            gap_ld   = 1'b1;
            gap_val  = GW'(T_RCD - 1);
            nx_state = ST_COL;
          end
        end
        ST_COL: begin
          nx_cmd                 = wr_q ? CMD_WR : CMD_RD;
          nx_ba                  = ba_q;
          nx_addr[COL_W-1:0]     = col_q;
          nx_addr[AP_BIT]        = 1'b1;
          gap_ld                 = 1'b1;
          gap_val                = wr_q ? GW'(POST_WR - 1) : GW'(POST_RD - 1);
          nx_state               = ST_IDLE;
        end
        default: nx_state = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_PWR;
      done_q <= 1'b0;
      ba_q   <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      state <= nx_state;
      if (state == ST_MRS && !busy) done_q <= 1'b1;
      if (take) begin
        ba_q  <= req_addr[ADDR_W-1 -: BANK_W];
        col_q <= req_addr[COL_W-1:0];
        wr_q  <= req_write;
      end
    end
  end
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned COL_W  = 9
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic                          req_write,
  input logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
  input logic                          init_done,
  input logic                          sd_cs_n,
  input logic                          sd_ras_n,
  input logic                          sd_cas_n,
  input logic                          sd_we_n,
  input logic [BANK_W-1:0]             sd_ba,
  input logic [ROW_W-1:0]              sd_addr
);
  localparam int unsigned ADDR_W = BANK_W + ROW_W + COL_W;
  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // R5
  act_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (cmd == CMD_ACT
      && sd_ba == $past(req_addr[ADDR_W-1 -: BANK_W])
      && sd_addr == $past(req_addr[COL_W +: ROW_W])));

  // R6
  col_ap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_RD || cmd == CMD_WR) |-> sd_addr[10]);

  // R2
  ready_init_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> init_done);

  // R2
  early_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !(cmd == CMD_ACT || cmd == CMD_RD || cmd == CMD_WR));

  // R7
  wr_recover_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WR) |=> (cmd == CMD_NOP));

  // R4
  mrs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_MRS) |=> (cmd == CMD_NOP));

  // R10
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |-> !req_ready);
endmodule

bind sdram_cmd_seq sdram_seq_chk #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_chk (.*);

// File: tb/sdram_cmd_seq_test.sv
module sdram_cmd_seq_test;
  localparam int TI = 20, TREFI = 120, RCD = 3, RP = 2, RC = 7, RAS = 4;
  localparam int RRD = 2, TWR = 3, MRD = 2, CL = 3;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                         C_NOP = 4'b0111;

  function automatic int bmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int SPAN  = bmax(RC, RRD);
  localparam int POSTR = bmax(bmax(SPAN, RAS + RP), RCD + 1) - RCD;
  localparam int POSTW = bmax(bmax(SPAN, RAS + RP), RCD + TWR + RP) - RCD;
  localparam int SLACK = RCD + POSTW;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [22:0] req_addr = '0;
  logic req_ready, init_done;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;

  sdram_cmd_seq #(.T_INIT(TI), .T_REFI(TREFI), .T_RCD(RCD), .T_RP(RP), .T_RC(RC),
    .T_RAS_MIN(RAS), .T_RRD(RRD), .T_WR(TWR), .T_MRD(MRD), .CAS_LAT(CL)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .init_done(init_done),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr));

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  int exp_ba[0:127], exp_row[0:127], exp_col[0:127];
  bit exp_w[0:127];
  int n_push = 0, n_act = 0, n_col = 0;

  int cyc = 0, earliest = 0, last_act = -1000, col_due = -1;
  int init_idx = 0, mrs_cyc = 0, n_ref = 0;
  bit quiet = 0;
  logic [3:0] cmd;

  always @(negedge clk) if (!rst) begin
    cyc++;
    cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (cmd != C_NOP) chk(cyc >= earliest, "R7 command before gap", cyc, earliest);
    if (cmd == C_PRE) begin
      chk(init_idx == 0 && cyc == TI, "R2 first command time", cyc, TI);
      chk(sd_addr[10] == 1'b1, "R3 precharge all flag", sd_addr[10], 1);
      chk(init_done == 1'b0, "R2 init_done low", init_done, 0);
      init_idx = 1; earliest = cyc + RP;
    end else if (cmd == C_REF) begin
      if (init_idx == 1) begin
        chk(cyc == TI + RP, "R3 first refresh", cyc, TI + RP);
        init_idx = 2; earliest = cyc + RC;
      end else if (init_idx == 2) begin
        chk(cyc == TI + RP + RC, "R3 second refresh", cyc, TI + RP + RC);
        init_idx = 3; earliest = cyc + RC;
      end else begin
        int d;
        d = (cyc - mrs_cyc - 1) % TREFI;
        chk(init_idx == 4 && d <= SLACK, "R8 R9 refresh delay", d, SLACK);
        if (quiet) chk(d == 0, "R8 quiet refresh phase", d, 0);
        chk(col_due < 0, "R6 refresh inside access", col_due, -1);
        n_ref++; earliest = cyc + RC;
      end
    end else if (cmd == C_MRS) begin
      chk(init_idx == 3 && cyc == TI + RP + 2 * RC, "R3 mode set time", cyc, TI + RP + 2 * RC);
      chk(sd_addr == 12'(CL << 4), "R3 mode word", sd_addr, CL << 4);
      chk(sd_ba == 2'd0, "R3 mode bank bits", sd_ba, 0);
      chk(init_done == 1'b1, "R4 init_done after mode set", init_done, 1);
      mrs_cyc = cyc; earliest = cyc + MRD; init_idx = 4;
    end else if (cmd == C_ACT) begin
      chk(init_idx == 4, "R2 activate before start-up", init_idx, 4);
      chk(cyc - last_act >= SPAN, "R7 activate spacing", cyc - last_act, SPAN);
      chk(sd_ba == exp_ba[n_act], "R5 activate bank", sd_ba, exp_ba[n_act]);
      chk(sd_addr == exp_row[n_act], "R5 activate row", sd_addr, exp_row[n_act]);
      n_act++; last_act = cyc; col_due = cyc + RCD; earliest = cyc + RCD;
    end else if (cmd == C_RD || cmd == C_WR) begin
      chk(cyc == col_due, "R6 column timing", cyc, col_due);
      chk((cmd == C_WR) == exp_w[n_col], "R6 direction", cmd, exp_w[n_col] ? C_WR : C_RD);
      chk(sd_ba == exp_ba[n_col], "R6 column bank", sd_ba, exp_ba[n_col]);
      chk(sd_addr == (12'h400 | 12'(exp_col[n_col])), "R6 column address", sd_addr,
          12'h400 | exp_col[n_col]);
      earliest = cyc + ((cmd == C_WR) ? POSTW : POSTR);
      n_col++; col_due = -1;
    end else if (cmd == C_NOP) begin
      if (col_due == cyc) chk(0, "R6 column missing", cyc, col_due);
      if (init_idx == 4 && req_valid && cyc >= earliest)
        chk(0, "R7 R9 idle while request waits", cyc, earliest);
    end else begin
      chk(0, "R1 illegal command code", cmd, C_NOP);
    end
    if (req_ready)
      chk(init_idx == 4 && col_due < 0 && cyc + 1 >= earliest, "R10 ready too early",
          cyc + 1, earliest);
  end

  task automatic issue(input bit w, input logic [22:0] a, input bit keep);
    req_valid = 1; req_write = w; req_addr = a;
    while (!req_ready) begin @(negedge clk); #1; end
    exp_ba[n_push] = a[22:21]; exp_row[n_push] = a[20:9];
    exp_col[n_push] = a[8:0]; exp_w[n_push] = w; n_push++;
    @(negedge clk); #1;
    if (!keep) req_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 reset command",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk(req_ready == 0 && init_done == 0, "R2 reset handshake", {req_ready, init_done}, 0);
    #1 rst = 0;
    while (!req_ready) begin @(negedge clk); #1; end
    // back-to-back sweep: every bank, both directions, spread of rows/columns
    for (int b = 0; b < 4; b++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 6; i++) begin
          logic [11:0] r;
          logic [8:0] c;
          r = 12'((b * 977 + i * 331 + w * 1501) & 12'hFFF);
          c = 9'((i * 97 + b * 13 + w * 255) & 9'h1FF);
          if (i == 5) begin r = 12'hFFF; c = 9'h1FF; end
          issue(w[0], {2'(b), r, c}, 1);
        end
    req_valid = 0;
    repeat (SLACK + 2) @(negedge clk);
    #1 quiet = 1;
    repeat (3 * TREFI + 5) @(negedge clk);
    #1 quiet = 0;
    // sparse traffic with varying gaps
    for (int i = 0; i < 16; i++) begin
      repeat (i % 5) @(negedge clk);
      #1 issue(i[0], {2'(3 - i % 4), 12'(i * 255), 9'(i * 31)}, 0);
    end
    repeat (20) @(negedge clk);
    chk(n_act == n_push, "R5 activate count", n_act, n_push);
    chk(n_col == n_push, "R6 column count", n_col, n_push);
    chk(n_ref >= (cyc - mrs_cyc - 1 - SLACK) / TREFI && n_ref <= (cyc - mrs_cyc - 1) / TREFI,
        "R8 refresh count", n_ref, (cyc - mrs_cyc - 1) / TREFI);
    summary();
  end
endmodule